// File: doc/BRIEF.md
# Timer Clock Select Prescaler

This block decides on which system clock cycles a timer counter may advance. It drives a single-cycle count-enable strobe and chooses the source of that strobe from a 3-bit select code. The code can stop the timer. It can let the timer count on every system clock. It can pick one of four fixed divisions (8, 64, 256, 1024) of a free-running 10-bit prescaler. It can also pick falling or rising edges of an external clock pin. A separate output reports whether any source is selected.

The select code is captured into a register that clears on reset. The external pin passes through two synchronizer flops and an edge detector. Each detected transition of the chosen polarity yields exactly one strobe. The detector looks only at the pin level and ignores how the pin's pad is configured. Software that drives the pin as an output can therefore step the counter by toggling it.

Top module: `tmr_clk_select`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count_en_o` and `running_o` are 0, whatever `clk_sel_i` holds, because the captured select code resets to 000.
- R2: With select 000, `count_en_o` stays 0 on every cycle.
- R3: With select 001, `count_en_o` is 1 on every cycle.
- R4: Selects 010, 011, 100 and 101 give single-cycle strobes spaced exactly 8, 64, 256 and 1024 system clocks apart. Any window of 2048 cycles therefore holds 256, 32, 8 and 2 strobes.
- R5: With select 110, each falling edge of `ext_clk_i` gives exactly one strobe, and rising edges give none. A pin change made before clock edge k shows as a strobe during the cycle after edge k+1.
- R6: With select 111, each rising edge of `ext_clk_i` gives exactly one strobe, and falling edges give none.
- R7: `running_o` is 1 exactly when the captured select code is not 000.
- R8: A value on `clk_sel_i` takes effect one clock after the edge that captures it.
- R9: With selects 000 to 101, activity on `ext_clk_i` has no effect on `count_en_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel_i | input | 3 | Count source select code |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| count_en_o | output | 1 | Single-cycle count-enable strobe |
| running_o | output | 1 | High when a count source is selected |

## Verification
On every cycle, the assertions check the following. No strobe appears while stopped. Every strobe coincides with `running_o`. Prescaler taps and edge pulses last one cycle. Rising and falling pulses are never both high. The captured select is 000 right after reset. Exact strobe spacing per division, the edge counts per pin polarity, the synchronizer latency and the immunity to pin activity in the prescaled modes are shown by the bench. It sweeps all eight codes and compares pulse counts and gaps with figures it computes itself.

// File: rtl/tmr_clk_select_pkg.sv
package tmr_clk_select_pkg;

    localparam int PRESC_W  = 10;
    localparam int NUM_TAPS = 4;
    localparam int SYNC_W   = 2;

    typedef enum logic [2:0] {
        CS_STOP     = 3'b000,
        CS_DIV1     = 3'b001,
        CS_DIV8     = 3'b010,
        CS_DIV64    = 3'b011,
        CS_DIV256   = 3'b100,
        CS_DIV1024  = 3'b101,
        CS_EXT_FALL = 3'b110,
        CS_EXT_RISE = 3'b111
    } clk_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } ext_edge_t;

    // log2 of the division ratio for each prescaler tap
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tmr_presc_taps.sv
module tmr_presc_taps
    import tmr_clk_select_pkg::*;
#(
    parameter int W     = PRESC_W,
    parameter int NTAPS = NUM_TAPS
) (
    input  logic             clk,
    input  logic             rst,
    output logic [NTAPS-1:0] tap_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        localparam int SH = tap_shift(i);
        logic tap_q;
        // registered: high on the cycle the low SH bits have wrapped to zero
        always_ff @(posedge clk) begin
            if (rst) tap_q <= 1'b0;
            else     tap_q <= (cnt_q[SH-1:0] == {SH{1'b1}});
        end
        assign tap_o[i] = tap_q;

        p_tap_single_r4: assert property (@(posedge clk) disable iff (rst)
            tap_q |=> !tap_q);
    end

endmodule

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge
    import tmr_clk_select_pkg::*;
#(
    parameter int STAGES = SYNC_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    output ext_edge_t edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign edge_o.rise = sync_q[STAGES-1] & ~last_q;
    assign edge_o.fall = ~sync_q[STAGES-1] & last_q;

    p_edge_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(edge_o.rise && edge_o.fall));
    p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
        edge_o.rise |=> !edge_o.rise);
    p_fall_single_r5: assert property (@(posedge clk) disable iff (rst)
        edge_o.fall |=> !edge_o.fall);

endmodule

// File: rtl/tmr_clk_select.sv
module tmr_clk_select
    import tmr_clk_select_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] clk_sel_i,
    input  logic       ext_clk_i,
    output logic       count_en_o,
    output logic       running_o
);

    clk_sel_e           sel_q;
    logic [NUM_TAPS-1:0] taps;
    ext_edge_t          ext_edge;
    logic               en_d;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= CS_STOP;
        else     sel_q <= clk_sel_e'(clk_sel_i);
    end

    tmr_presc_taps #(.W(PRESC_W), .NTAPS(NUM_TAPS)) presc_i (
        .clk   (clk),
        .rst   (rst),
        .tap_o (taps)
    );

    tmr_ext_edge #(.STAGES(SYNC_W)) ext_i (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_clk_i),
        .edge_o (ext_edge)
    );

    always_comb begin
        case (sel_q)
            CS_DIV1:     en_d = 1'b1;
            CS_DIV8:     en_d = taps[0];
            CS_DIV64:    en_d = taps[1];
            CS_DIV256:   en_d = taps[2];
            CS_DIV1024:  en_d = taps[3];
            CS_EXT_FALL: en_d = ext_edge.fall;
            CS_EXT_RISE: en_d = ext_edge.rise;
            default:     en_d = 1'b0;
        endcase
    end

    assign count_en_o = en_d;
    assign running_o  = (sel_q != CS_STOP);

    p_stop_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (sel_q == CS_STOP) |-> !count_en_o);
    p_en_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
        count_en_o |-> running_o);
    p_sel_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_q == CS_STOP));

endmodule

// File: tb/tmr_clk_select_tb_top.sv
module tmr_clk_select_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'b000;
    logic       pin = 1'b0;
    logic       en;
    logic       run;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tmr_clk_select dut_i (
        .clk        (clk),
        .rst        (rst),
        .clk_sel_i  (sel),
        .ext_clk_i  (pin),
        .count_en_o (en),
        .running_o  (run)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count strobes over len cycles, also record worst gap mismatch
    task automatic count_win(input int len, input int gap, output int pulses, output int bad);
        int last;
        pulses = 0; bad = 0; last = -1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (en) begin
                if (last >= 0 && (i - last) != gap) bad++;
                last = i;
                pulses++;
            end
        end
    endtask

    // toggle pin ntog times, hold cycles between, count strobes
    task automatic toggle_count(input int ntog, input int hold, output int pulses);
        pulses = 0;
        for (int t = 0; t < ntog; t++) begin
            pin = ~pin;
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                if (en) pulses++;
            end
        end
    endtask

    initial begin
        int p, b, exp_p;
        int divs[4] = '{8, 64, 256, 1024};
        // R1: reset with a nonzero select held on the input
        sel = 3'b001;
        cyc(3);
        check(en == 0 && run == 0, "R1 during reset", {en, run}, 0);
        @(negedge clk) rst = 1'b0;
        // first edge without reset loads sel; before it outputs remain idle
        check(en == 0 && run == 0, "R1 after reset", {en, run}, 0);
        // R8: value becomes visible after the capturing edge
        @(negedge clk);
        check(run == 1 && en == 1, "R8 select latency", {en, run}, 3);

        // R3: every cycle
        count_win(2048, 1, p, b);
        check(p == 2048 && b == 0, "R3 div1 count", p, 2048);
        check(run == 1, "R7 running div1", run, 1);

        // R2: stop
        sel = 3'b000;
        cyc(2);
        check(run == 0, "R7 running stop", run, 0);
        count_win(2048, 1, p, b);
        check(p == 0, "R2 stop count", p, 0);

        // R4: prescaled divisions
        for (int d = 0; d < 4; d++) begin
            sel = 3'(d + 2);
            cyc(2);
            count_win(2048, divs[d], p, b);
            exp_p = 2048 / divs[d];
            check(p == exp_p, $sformatf("R4 div%0d count", divs[d]), p, exp_p);
            check(b == 0, $sformatf("R4 div%0d spacing", divs[d]), b, 0);
            check(run == 1, "R7 running div", run, 1);
        end

        // R9: pin activity ignored with div8, stop and div1
        sel = 3'b010;
        cyc(2);
        p = 0;
        for (int i = 0; i < 2048; i++) begin
            if (i % 3 == 0) pin = ~pin;
            @(negedge clk);
            if (en) p++;
        end
        check(p == 256, "R9 div8 with pin toggling", p, 256);
        sel = 3'b000;
        cyc(2);
        toggle_count(20, 4, p);
        check(p == 0, "R9 stop with pin toggling", p, 0);
        sel = 3'b001;
        cyc(2);
        toggle_count(10, 5, p);
        check(p == 50, "R9 div1 with pin toggling", p, 50);

        // R5: falling edges only; settle pin low first
        pin = 1'b0;
        sel = 3'b110;
        cyc(6);
        toggle_count(10, 6, p);
        check(p == 5, "R5 falling edge count", p, 5);
        // latency: pin is low now, raise it (no strobe), then drop it
        pin = 1'b1;
        cyc(6);
        pin = 1'b0;          // changed before edge k
        @(negedge clk);      // after edge k
        check(en == 0, "R5 no strobe after one edge", en, 0);
        @(negedge clk);      // after edge k+1
        check(en == 1, "R5 strobe after two edges", en, 1);
        @(negedge clk);
        check(en == 0, "R5 strobe lasts one cycle", en, 0);

        // R6: rising edges only
        sel = 3'b111;
        cyc(6);
        toggle_count(12, 5, p);
        check(p == 6, "R6 rising edge count", p, 6);
        pin = 1'b1;
        cyc(6);
        pin = 1'b0;
        cyc(6);
        pin = 1'b1;
        @(negedge clk);
        check(en == 0, "R6 no strobe after one edge", en, 0);
        @(negedge clk);
        check(en == 1, "R6 strobe after two edges", en, 1);
        @(negedge clk);
        check(en == 0, "R6 strobe lasts one cycle", en, 0);

        // R1: mid-run reset clears the select
        rst = 1'b1;
        cyc(2);
        check(run == 0 && en == 0, "R1 mid-run reset", {en, run}, 0);
        rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule